// File: doc/BRIEF.md
# Floating-point exception status and trap unit

This block holds the exception part of a floating-point status register and decides, when an FP operation completes, whether that operation traps. At the start of every FP instruction it wipes the current-exception and trap-type fields. When the arithmetic datapath reports completion, it receives five raw IEEE flags for that operation alone. It merges them into the current-exception field and tests them against the trap-enable mask. If an enabled flag is present, it records the IEEE trap-type code and raises a trap request. Otherwise the flags are folded into the accrued-exception field.

Software can overwrite the whole register. Such a write wins over a completion in the same cycle. The register value is always visible on an output port, so the control logic and the write-back path can read it. The arithmetic itself is not part of this block.

Top module: `fpx_status_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `fsr_o` is zero and `fp_trap_o` is low.
- R2: A cycle with `op_start_i` high and no write clears the current-exception field (bits 4:0) and the trap-type field (bits 16:14). All other bits keep their value.
- R3: Flag bits map one-for-one into the current-exception field, which becomes its previous value OR the flags. The flag order is bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. If `op_start_i` is high in the same cycle, the previous value is taken as zero.
- R4: A completion whose flag vector is all zero leaves the register unchanged (apart from any R2 clearing in the same cycle) and raises no trap.
- R5: A completion traps when the new current-exception field ANDed with the enable mask in bits 27:23 is non-zero. The trap sets the trap-type field to 3'b001 and leaves the accrued field (bits 9:5) unchanged.
- R6: A completion with flags and no enabled match ORs the new current-exception field into the accrued field (bits 9:5) and raises no trap.
- R7: A software write in the same cycle as a completion discards that completion, so there is no field update and no trap.
- R8: A software write stores all 32 bits, and they appear on `fsr_o` in the next cycle.
- R9: `fp_trap_o` is high for exactly the cycle after a trapping completion, the same cycle in which `fsr_o` first shows the trap-type code.
- R10: When start and completion arrive in the same cycle, the clearing is applied first, so the current-exception field holds exactly the new flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_start_i | input | 1 | Start of an FP instruction |
| op_done_i | input | 1 | FP operation completed; flags are valid |
| op_flags_i | input | 5 | Raw IEEE flags of the completed operation |
| csr_we_i | input | 1 | Software write enable |
| csr_wdata_i | input | 32 | Software write data |
| fsr_o | output | 32 | Current status register value |
| fp_trap_o | output | 1 | FP exception trap request pulse |

## Verification
Directed cases first try a single flag with the whole mask disabled, which separates accrual from trapping. Next comes a flag that matches one enabled mask bit, which shows the shift between the enable field and the flag field. An all-zero flag vector shows that a completion with no flags does nothing. Collisions of start with completion, and of a write with completion, expose the ordering and priority rules. A long seeded random mix then varies the mask, the flags, any leftover current-exception bits and the strobe overlaps. This separates a test on the new flags alone from a test on the merged field, and accrual of the merged field from accrual of the raw flags.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FSR_W    = 32;
  localparam int NFLAG    = 5;
  localparam int CEXC_LSB = 0;
  localparam int AEXC_LSB = 5;
  localparam int FTT_LSB  = 14;
  localparam int FTT_W    = 3;
  localparam int TEM_LSB  = 23;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

  // flag vector bit positions
  typedef enum int {
    FL_NX = 0,
    FL_DZ = 1,
    FL_UF = 2,
    FL_OF = 3,
    FL_NV = 4
  } flag_idx_e;
endpackage

// File: rtl/fpx_trap_decide.sv
module fpx_trap_decide #(
  parameter int NFLAG = fpx_pkg::NFLAG
) (
  input  logic [NFLAG-1:0] cexc_base_i,
  input  logic [NFLAG-1:0] raw_flags_i,
  input  logic [NFLAG-1:0] tem_i,
  output logic [NFLAG-1:0] cexc_next_o,
  output logic             raised_o,
  output logic             fire_o
);
  logic [NFLAG-1:0] hit;

  assign cexc_next_o = cexc_base_i | raw_flags_i;
  assign raised_o    = |raw_flags_i;

  for (genvar i = 0; i < NFLAG; i++) begin : g_hit
    assign hit[i] = cexc_next_o[i] & tem_i[i];
  end

  assign fire_o = raised_o & (|hit);
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg #(
  parameter int FSR_W    = fpx_pkg::FSR_W,
  parameter int NFLAG    = fpx_pkg::NFLAG,
  parameter int CEXC_LSB = fpx_pkg::CEXC_LSB,
  parameter int AEXC_LSB = fpx_pkg::AEXC_LSB,
  parameter int FTT_LSB  = fpx_pkg::FTT_LSB,
  parameter int FTT_W    = fpx_pkg::FTT_W,
  parameter int TEM_LSB  = fpx_pkg::TEM_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [NFLAG-1:0] flags_i,
  input  logic             wr_en_i,
  input  logic [FSR_W-1:0] wr_data_i,
  input  logic [NFLAG-1:0] cexc_next_i,
  input  logic             raised_i,
  input  logic             fire_i,
  output logic [NFLAG-1:0] cexc_base_o,
  output logic [NFLAG-1:0] tem_o,
  output logic [FSR_W-1:0] fsr_o,
  output logic             trap_o
);
  logic [FSR_W-1:0] fsr_q, fsr_d;
  logic             trap_q, trap_d;

  // start clears cexc before the new flags merge
  assign cexc_base_o = start_i ? '0 : fsr_q[CEXC_LSB +: NFLAG];
  assign tem_o       = fsr_q[TEM_LSB +: NFLAG];

  always_comb begin
    fsr_d  = fsr_q;
    trap_d = 1'b0;
    if (wr_en_i) begin
      fsr_d = wr_data_i;
    end else begin
      if (start_i) begin
        fsr_d[CEXC_LSB +: NFLAG] = '0;
        fsr_d[FTT_LSB +: FTT_W]  = '0;
      end
      if (done_i && raised_i) begin
        fsr_d[CEXC_LSB +: NFLAG] = cexc_next_i;
        if (fire_i) begin
          fsr_d[FTT_LSB +: FTT_W] = fpx_pkg::FTT_IEEE;
          trap_d = 1'b1;
        end else begin
          fsr_d[AEXC_LSB +: NFLAG] = fsr_d[AEXC_LSB +: NFLAG] | cexc_next_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      fsr_q  <= fsr_d;
      trap_q <= trap_d;
    end
  end

  assign fsr_o  = fsr_q;
  assign trap_o = trap_q;

  // R2
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wr_en_i && !done_i) |=>
      (fsr_q[CEXC_LSB +: NFLAG] == '0 && fsr_q[FTT_LSB +: FTT_W] == '0));

  // R4
  no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && flags_i == '0 && !wr_en_i && !start_i) |=> ($stable(fsr_q) && !trap_q));

  // R5
  trap_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> (fsr_q[FTT_LSB +: FTT_W] == fpx_pkg::FTT_IEEE));

  // R6
  accrue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_en_i && flags_i != '0) |=>
      (trap_q || ((fsr_q[AEXC_LSB +: NFLAG] & $past(flags_i)) == $past(flags_i))));

  // R7
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (fsr_q == $past(wr_data_i) && !trap_q));
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit #(
  parameter int FSR_W = fpx_pkg::FSR_W,
  parameter int NFLAG = fpx_pkg::NFLAG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_start_i,
  input  logic             op_done_i,
  input  logic [NFLAG-1:0] op_flags_i,
  input  logic             csr_we_i,
  input  logic [FSR_W-1:0] csr_wdata_i,
  output logic [FSR_W-1:0] fsr_o,
  output logic             fp_trap_o
);
  logic [NFLAG-1:0] cexc_base, cexc_next, tem;
  logic             raised, fire;

  fpx_trap_decide #(.NFLAG(NFLAG)) u_decide (
    .cexc_base_i (cexc_base),
    .raw_flags_i (op_flags_i),
    .tem_i       (tem),
    .cexc_next_o (cexc_next),
    .raised_o    (raised),
    .fire_o      (fire)
  );

  fpx_status_reg #(.FSR_W(FSR_W), .NFLAG(NFLAG)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (op_start_i),
    .done_i      (op_done_i),
    .flags_i     (op_flags_i),
    .wr_en_i     (csr_we_i),
    .wr_data_i   (csr_wdata_i),
    .cexc_next_i (cexc_next),
    .raised_i    (raised),
    .fire_i      (fire),
    .cexc_base_o (cexc_base),
    .tem_o       (tem),
    .fsr_o       (fsr_o),
    .trap_o      (fp_trap_o)
  );

  // R9
  trap_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_trap_o |-> $past(op_done_i && !csr_we_i && op_flags_i != '0));
endmodule

// File: tb/tb_fpx_status_unit.sv
module tb_fpx_status_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_start_i = 1'b0, op_done_i = 1'b0, csr_we_i = 1'b0;
  logic [4:0]  op_flags_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] fsr_o;
  logic        fp_trap_o;

  int checks = 0, fails = 0;
  logic [31:0] exp_fsr = '0;
  logic        exp_trap = 1'b0;

  always #2 clk_i = ~clk_i;

  fpx_status_unit dut (.*);

  // reference from the requirements: returns {trap, fsr}
  function automatic logic [32:0] model(input logic [31:0] f, input logic st, input logic dn,
                                        input logic [4:0] fl, input logic we, input logic [31:0] wd);
    logic [31:0] n = f;
    logic [4:0]  c;
    logic        t = 1'b0;
    if (we) return {1'b0, wd};
    if (st) begin n[4:0] = '0; n[16:14] = '0; end
    if (dn && fl != 0) begin
      c = n[4:0] | fl;
      n[4:0] = c;
      if ((c & f[27:23]) != 0) begin n[16:14] = 3'd1; t = 1'b1; end
      else n[9:5] = n[9:5] | c;
    end
    return {t, n};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic st, input logic dn, input logic [4:0] fl,
                      input logic we, input logic [31:0] wd);
    logic [32:0] m;
    @(negedge clk_i);
    op_start_i = st; op_done_i = dn; op_flags_i = fl; csr_we_i = we; csr_wdata_i = wd;
    m = model(exp_fsr, st, dn, fl, we, wd);
    @(posedge clk_i); #1;
    exp_fsr = m[31:0]; exp_trap = m[32];
    chk(req, fsr_o, exp_fsr);
    chk(req, {31'd0, fp_trap_o}, {31'd0, exp_trap});
    op_start_i = 0; op_done_i = 0; csr_we_i = 0; op_flags_i = '0;
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd2718);
    #1; chk("R1", fsr_o, 32'd0); chk("R1", {31'd0, fp_trap_o}, 32'd0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1", fsr_o, 32'd0); chk("R1", {31'd0, fp_trap_o}, 32'd0);

    // R8 full write, mask off
    step("R8", 0, 0, 0, 1, 32'h4005_C21F);
    // R2 start clears cexc and ftt only
    step("R2", 1, 0, 0, 0, 0);
    chk("R2", fsr_o & 32'h0001_C01F, 32'd0);
    chk("R2", fsr_o & ~32'h0001_C01F, 32'h4005_C21F & ~32'h0001_C01F);
    // R3 / R6 invalid flag, mask disabled -> accrue
    step("R3", 0, 1, 5'b10000, 0, 0);
    chk("R6", fsr_o[9:5] & 5'b10000, 5'b10000);
    // R4 zero flags
    step("R4", 0, 1, 5'b00000, 0, 0);
    // R5 enable overflow mask (bit 26), start then overflow
    step("R8", 0, 0, 0, 1, 32'h0400_0000);
    step("R2", 1, 0, 0, 0, 0);
    step("R5", 0, 1, 5'b01000, 0, 0);
    chk("R5", {29'd0, fsr_o[16:14]}, 32'd1);
    chk("R5", {27'd0, fsr_o[9:5]}, 32'd0);
    chk("R9", {31'd0, fp_trap_o}, 32'd1);
    step("R9", 0, 0, 0, 0, 0);
    chk("R9", {31'd0, fp_trap_o}, 32'd0);
    // R7 write collides with trapping completion
    step("R7", 0, 1, 5'b01000, 1, 32'h0400_0003);
    // R10 start and completion together: cexc = new flags only
    step("R10", 1, 1, 5'b00001, 0, 0);
    chk("R10", {27'd0, fsr_o[4:0]}, 32'd1);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] wd;
      logic we, st, dn;
      logic [4:0] fl;
      r = $urandom;
      we = (r[3:0] == 0);
      st = (r[5:4] == 0);
      dn = (r[7:6] != 0);
      fl = (r[9:8] == 0) ? 5'd0 : 5'(r >> 10);
      wd = $urandom & 32'h0F81_C3FF;
      step("R3_R5_R6", st, dn, fl, we, wd);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule